// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block derives the core logic's master clock from a fast reference clock (nominally 48 MHz). The divide ratio is one plus half a 6-bit configuration code, so codes 0 to 63 cover ratios from 1.0 to 32.5 in half steps. The block does not create a new clock net. It runs entirely on the reference clock and produces a one-cycle enable, `tick_o`, once per divided period. For half-integer ratios the period lengths alternate between the floor of the ratio and one cycle more, so the average ratio is exact. A second enable, `conv_o`, marks every eighth master period and paces the converter. At a 48 MHz reference this gives roughly 1.48 to 48 MHz for the master rate and 184 kHz to 6 MHz for conversions.

The code input is plain control and has no handshake. It is sampled only on the last cycle of each master period, and that sampled value governs the whole next period. A change written in mid-period therefore never shortens or stretches the period in progress. Reset is synchronous and active low, and it clears the held code to 0.

Top module: `hsdiv_top`

## Requirements
- R1: For an even code c held steady, `tick_o` is high for exactly one cycle every c/2+1 reference cycles.
- R2: For an odd code c held steady, the gaps between `tick_o` pulses alternate between (c-1)/2+1 and (c-1)/2+2 cycles, so every two periods last exactly c+2 cycles.
- R3: With code 0, `tick_o` is high on every reference cycle.
- R4: The code is captured only in a cycle where `tick_o` is high. A change applied mid-period leaves the length of that period unchanged, and the new ratio applies from the next period.
- R5: `conv_o` is high only in cycles where `tick_o` is high, and exactly once per eight `tick_o` pulses.
- R6: After reset the held code is 0. The first cycle after reset release carries a `tick_o` pulse whatever `code_i` is, and `conv_o` stays low during reset. The first `conv_o` coincides with the eighth `tick_o` after release.
- R7: At the top code 63 the periods alternate between 32 and 33 cycles (ratio 32.5), and no period is ever longer than 33 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| code_i | input | 6 | Divide code; ratio = 1 + code/2 |
| tick_o | output | 1 | One-cycle master-rate enable |
| conv_o | output | 1 | One-cycle conversion enable, every eighth tick |

## Verification
The checker assumes that `code_i` may change at any cycle. It treats as the governing value for a period only the code seen on the tick that opens that period, so its period and alternation properties hold against arbitrary code traffic. The alternation property is armed only when the same odd code has governed two consecutive periods. The bench changes codes at negative edges, both on and off period boundaries, and discards the periods that straddle each change before it measures, so every measured period falls under a single code.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

  // Shortest period (cycles) a code can produce: floor(code/2) + 1.
  function automatic int unsigned short_len(input int unsigned code);
    return (code >> 1) + 1;
  endfunction

  typedef enum logic {PH_SHORT = 1'b0, PH_LONG = 1'b1} phase_e;

endpackage

// File: rtl/hsdiv_phase.sv
module hsdiv_phase #(
  parameter int CODE_W = 6,
  localparam int LEN_W = CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LEN_W-1:0]  len_o
);
  import hsdiv_pkg::*;

  logic [CODE_W-1:0] code_q;
  phase_e            phase_q;
  logic [LEN_W-1:0]  base_len;

  // Code and long/short phase only move on a period boundary.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      code_q  <= '0;
      phase_q <= PH_SHORT;
    end else if (tick_i) begin
      code_q <= code_i;
      // odd codes alternate short and long periods; even codes stay short
      if (code_i[0] && phase_q == PH_SHORT) phase_q <= PH_LONG;
      else                                  phase_q <= PH_SHORT;
    end
  end

  assign base_len = {1'b0, code_q[CODE_W-1:1]} + LEN_W'(1);
  assign len_o    = base_len + LEN_W'(code_q[0] && phase_q == PH_LONG);

endmodule

// File: rtl/hsdiv_count.sv
module hsdiv_count #(
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] len_i,
  output logic             tick_o
);
  logic [LEN_W-1:0] cnt_q;

  assign tick_o = (cnt_q == len_i - LEN_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + LEN_W'(1);
  end

endmodule

// File: rtl/hsdiv_conv.sv
module hsdiv_conv #(
  parameter int CONV_DIV = 8,
  localparam int CONV_W = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic conv_o
);
  generate
    if (CONV_DIV == 1) begin : g_pass
      assign conv_o = tick_i;
    end else begin : g_cnt
      logic [CONV_W-1:0] tcnt_q;
      logic              last;
      assign last   = (tcnt_q == CONV_W'(CONV_DIV - 1));
      assign conv_o = tick_i && last;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)     tcnt_q <= '0;
        else if (tick_i) tcnt_q <= last ? '0 : tcnt_q + CONV_W'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/hsdiv_top.sv
module hsdiv_top #(
  parameter int CODE_W   = 6,
  parameter int CONV_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o,
  output logic              conv_o
);
  localparam int LEN_W = CODE_W;

  logic [LEN_W-1:0] len;

  hsdiv_phase #(.CODE_W(CODE_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_o),
    .code_i (code_i),
    .len_o  (len)
  );

  hsdiv_count #(.LEN_W(LEN_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (len),
    .tick_o (tick_o)
  );

  hsdiv_conv #(.CONV_DIV(CONV_DIV)) u_conv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_o),
    .conv_o (conv_o)
  );

endmodule

// File: rtl/hsdiv_top_chk.sv
module hsdiv_top_chk #(
  parameter int CODE_W   = 6,
  parameter int CONV_DIV = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              tick_o,
  input logic              conv_o
);
  localparam int GAP_W  = CODE_W + 1;
  localparam int MAXLEN = (1 << (CODE_W - 1)) + 1;
  localparam int TC_W   = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;

  logic [GAP_W-1:0]  gap_q, prev_gap_q, shortp;
  logic [CODE_W-1:0] cur_code_q, prev_code_q;
  logic              prev_ok_q, first_q;
  logic [TC_W-1:0]   seen_q;

  assign shortp = GAP_W'(cur_code_q >> 1) + GAP_W'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gap_q <= GAP_W'(1); prev_gap_q <= '0; cur_code_q <= '0; prev_code_q <= '0;
      prev_ok_q <= 1'b0; first_q <= 1'b1; seen_q <= '0;
    end else begin
      first_q <= 1'b0;
      if (tick_o) begin
        gap_q       <= GAP_W'(1);
        prev_gap_q  <= gap_q;
        prev_code_q <= cur_code_q;
        cur_code_q  <= code_i;
        prev_ok_q   <= 1'b1;
        seen_q      <= (seen_q == TC_W'(CONV_DIV - 1)) ? '0 : seen_q + TC_W'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  AST_EVEN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !cur_code_q[0]) |-> gap_q == shortp);                               // R1
  AST_ODD_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cur_code_q[0]) |-> (gap_q == shortp || gap_q == shortp + GAP_W'(1))); // R2
  AST_ODD_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cur_code_q[0] && prev_ok_q && prev_code_q == cur_code_q) |-> gap_q != prev_gap_q); // R2
  AST_ZERO_SOLID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_code_q == '0) |-> tick_o);                                                 // R3
  AST_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> gap_q < shortp + GAP_W'(cur_code_q[0]));                            // R4
  AST_CONV_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> tick_o);                                                             // R5
  AST_CONV_EIGHTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (conv_o == (seen_q == TC_W'(CONV_DIV - 1))));                         // R5
  AST_FIRST_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> tick_o);                                                            // R6
  AST_MAX_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_W'(MAXLEN));                                                       // R7

endmodule

bind hsdiv_top hsdiv_top_chk #(.CODE_W(CODE_W), .CONV_DIV(CONV_DIV)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .code_i (code_i),
  .tick_o (tick_o),
  .conv_o (conv_o)
);

// File: tb/tb_hsdiv_top.sv
module tb_hsdiv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] code = 6'd0;
  logic       tick, conv;
  int         n_run = 0, n_fail = 0;

  localparam int NV = 8;
  localparam logic [5:0] V_CODE  [NV] = '{6'd0, 6'd1, 6'd2, 6'd7, 6'd20, 6'd33, 6'd62, 6'd63};
  localparam logic [5:0] V_SHORT [NV] = '{6'd1, 6'd1, 6'd2, 6'd4, 6'd11, 6'd17, 6'd32, 6'd32};
  localparam logic [5:0] V_LONG  [NV] = '{6'd1, 6'd2, 6'd2, 6'd5, 6'd11, 6'd18, 6'd32, 6'd33};

  always #10 clk = ~clk;

  hsdiv_top dut (.clk_i(clk), .rst_ni(rst_n), .code_i(code), .tick_o(tick), .conv_o(conv));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cycles from the current sample point to the next sampled tick
  task automatic next_gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int g, gp, cyc;
    string rq;
    // R6: reset state
    code = 6'd10;
    repeat (3) @(negedge clk);
    check(conv == 1'b0, "R6 conv in reset", int'(conv), 0);
    rst_n = 1'b1;
    #1;
    check(tick == 1'b1, "R6 first tick", int'(tick), 1);
    next_gap(g);
    check(g == 6, "R6 code loads after first period", g, 6);
    check(conv == 1'b0, "R6 no conv on tick 2", int'(conv), 0);
    for (int j = 3; j <= 8; j++) begin
      next_gap(g);
      check(conv == (j == 8), "R6 first conv on tick 8", int'(conv), int'(j == 8));
    end

    // vector table: R1, R2, R3, R7
    for (int i = 0; i < NV; i++) begin
      code = V_CODE[i];
      next_gap(g); next_gap(g);
      rq = (V_CODE[i] == 0) ? "R3" : (V_CODE[i] == 63) ? "R7" : V_CODE[i][0] ? "R2" : "R1";
      gp = 0;
      for (int k = 0; k < 4; k++) begin
        next_gap(g);
        if (!V_CODE[i][0])
          check(g == int'(V_SHORT[i]), rq, g, int'(V_SHORT[i]));
        else begin
          check((g == int'(V_SHORT[i]) || g == int'(V_LONG[i])) && (k == 0 || g != gp),
                rq, g, (gp == int'(V_SHORT[i])) ? int'(V_LONG[i]) : int'(V_SHORT[i]));
          if (k > 0)
            check(g + gp == int'(V_CODE[i]) + 2, rq, g + gp, int'(V_CODE[i]) + 2);
        end
        gp = g;
      end
    end

    // R4: change mid-period; current period keeps its length
    code = 6'd8;
    next_gap(g); next_gap(g);
    g = 0;
    repeat (2) begin @(negedge clk); g++; end
    code = 6'd0;
    do begin @(negedge clk); g++; end while (!tick);
    check(g == 5, "R4 period in flight", g, 5);
    next_gap(g);
    check(g == 1, "R4 new code next period", g, 1);

    // R5: conv spacing with ratio 2 is 16 cycles, only on ticks
    code = 6'd2;
    do @(negedge clk); while (!conv);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
      if (conv && !tick) check(1'b0, "R5 conv off tick", 1, 0);
    end while (!conv);
    check(cyc == 16, "R5 conv spacing", cyc, 16);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule